// File: doc/BRIEF.md
# Division Step Unit

One iteration of a 32-bit non-restoring unsigned division. Each call takes a partial remainder and a divisor and produces the next partial remainder in the same cycle. A small status register carries state from one iteration to the next: a carry bit, the per-bit carry vector and an add/subtract flag. Whether the iteration adds or subtracts the divisor is chosen by that flag. The flag is then recomputed from the carry-out and the divisor's sign.

A controller or a software loop issues the unit 32 times and feeds each new remainder back in as the next partial remainder. The status flags change only on cycles where the step-valid input is high. A nonzero 4-bit condition selector evaluates an arithmetic predicate on the step's result. The caller uses that predicate to skip the next operation.

Top module: `dstep_unit`

## Requirements
- R1: The first operand is the partial remainder shifted left by one place, with the stored carry bit in bit 0. Consequently `next_rem[0]` always equals `carry_msb ^ divisor[0]`.
- R2: With the stored flag `v_flag` at 0 the step computes shifted + divisor. With `v_flag` at 1 it computes shifted + ~divisor + 1. The result is `next_rem`, modulo 2^32, visible in the same cycle.
- R3: On a clock edge with `step_valid` high and `rst_n` high, `carry_msb` takes the carry-out of bit 31 of the R2 sum.
- R4: On such an edge, `carry_vec` takes shifted ^ addend ^ result. Here addend is divisor or ~divisor as chosen by R2, so `carry_vec[0]` equals the previous `v_flag`.
- R5: On such an edge, `v_flag` takes the carry-out of R2 XOR `divisor[31]`.
- R6: For a nonzero `cond_sel`, `cond_hit` is the predicate picked by `cond_sel[3:1]`, inverted when `cond_sel[0]` is 1. The predicates are evaluated on the current step's result, carry-out and signed add overflow. The codes are:
  - 0: false
  - 1: result is zero
  - 2: result bit 31 is set
  - 3: result bit 31 is set or the result is zero
  - 4: no carry-out
  - 5: no carry-out or the result is zero
  - 6: signed overflow of shifted + addend, taken from bit 31
  - 7: result bit 0 is set
- R7: With `cond_sel` equal to 0, `cond_hit` is 0.
- R8: On a clock edge with `step_valid` low, `carry_msb`, `v_flag` and `carry_vec` keep their values.
- R9: A clock edge with `rst_n` low clears `carry_msb`, `v_flag` and `carry_vec` to 0, whatever `step_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Commit this step's flags at the next edge |
| part_rem | input | 32 | Partial remainder operand |
| divisor | input | 32 | Divisor operand |
| cond_sel | input | 4 | Condition selector; 0 means no condition |
| next_rem | output | 32 | New partial remainder (combinational) |
| cond_hit | output | 1 | Selected condition outcome (combinational) |
| carry_msb | output | 1 | Stored carry bit |
| v_flag | output | 1 | Stored add/subtract flag |
| carry_vec | output | 32 | Stored per-bit carry vector |

## Verification
`next_rem` and `cond_hit` are due in the same cycle as the operands that produce them. The stored `carry_msb`, `v_flag` and `carry_vec` show a step's effect only one clock edge later. The driver therefore sets operands just after a rising edge and queues the expected combinational values together with the flag values the bench model holds at that moment. The monitor pops and compares each item on the following falling edge, so every stored flag is checked against the state committed by the previous valid step. Priming steps, long 32-step chains, hold cycles and a mid-run reset exercise both adder modes and the flag-retention paths.

// File: rtl/dstep_pkg.sv
// Package: shared widths and condition codes for the division step unit.
// Assumes a two's-complement datapath; the selector encoding is fixed by R6.
package dstep_pkg;
    localparam int DSTEP_W  = 32;
    localparam int COND_W   = 4;

    typedef enum logic [2:0] {
        PRED_NEVER   = 3'd0,
        PRED_ZERO    = 3'd1,
        PRED_NEG     = 3'd2,
        PRED_NEG_Z   = 3'd3,
        PRED_NOCARRY = 3'd4,
        PRED_NC_Z    = 3'd5,
        PRED_OVF     = 3'd6,
        PRED_ODD     = 3'd7
    } pred_e;
endpackage

// File: rtl/dstep_adder.sv
// Module: dstep_adder
// Forms the shifted operand, chooses the addend from the mode flag and adds.
// Assumes the mode flag also supplies the carry-in (the +1 of a subtract).
module dstep_adder #(
    parameter int W = dstep_pkg::DSTEP_W
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] div_i,
    input  logic         cb_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic [W-1:0] cvec_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] shifted;
    logic [W-1:0] addend;
    logic [W:0]   wide_sum;

    // Operand preparation: shift in the carry, pick true or inverted divisor.
    always_comb begin
        shifted = {rem_i[W-2:0], cb_i};
        addend  = sub_i ? ~div_i : div_i;
    end

    // Wide addition so the carry-out of the top bit is kept.
    always_comb begin
        wide_sum = {1'b0, shifted} + {1'b0, addend} + {{W{1'b0}}, sub_i};
        sum_o    = wide_sum[W-1:0];
        cout_o   = wide_sum[W];
    end

    // Per-bit carry-in vector and signed overflow of the addition.
    always_comb begin
        cvec_o = shifted ^ addend ^ sum_o;
        ovf_o  = (shifted[MSB] ~^ addend[MSB]) & (sum_o[MSB] ^ shifted[MSB]);
    end
endmodule

// File: rtl/dstep_cond.sv
// Module: dstep_cond
// Evaluates the selected predicate on the step result, carry-out and overflow.
// Assumes a zero selector means "no condition" and yields 0.
module dstep_cond #(
    parameter int W = dstep_pkg::DSTEP_W
) (
    input  logic [W-1:0]                  res_i,
    input  logic                          cout_i,
    input  logic                          ovf_i,
    input  logic [dstep_pkg::COND_W-1:0]  sel_i,
    output logic                          hit_o
);
    import dstep_pkg::*;

    logic  is_zero;
    logic  raw;
    pred_e pred;

    // Decode the predicate code from the upper selector bits.
    always_comb begin
        pred    = pred_e'(sel_i[3:1]);
        is_zero = (res_i == '0);
    end

    // Predicate evaluation.
    always_comb begin
        unique case (pred)
            PRED_NEVER:   raw = 1'b0;
            PRED_ZERO:    raw = is_zero;
            PRED_NEG:     raw = res_i[W-1];
            PRED_NEG_Z:   raw = res_i[W-1] | is_zero;
            PRED_NOCARRY: raw = ~cout_i;
            PRED_NC_Z:    raw = ~cout_i | is_zero;
            PRED_OVF:     raw = ovf_i;
            PRED_ODD:     raw = res_i[0];
            default:      raw = 1'b0;
        endcase
    end

    // Apply the inversion bit; a zero selector forces no hit.
    always_comb begin
        hit_o = (sel_i == '0) ? 1'b0 : (raw ^ sel_i[0]);
    end
endmodule

// File: rtl/dstep_status.sv
// Module: dstep_status
// Holds carry bit, carry vector and mode flag between steps.
// Assumes synchronous active-low reset that takes priority over the load.
module dstep_status #(
    parameter int W = dstep_pkg::DSTEP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         cb_d,
    input  logic         v_d,
    input  logic [W-1:0] cvec_d,
    output logic         cb_q,
    output logic         v_q,
    output logic [W-1:0] cvec_q
);
    // Status register: clear on reset, load on a valid step, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_q   <= 1'b0;
            v_q    <= 1'b0;
            cvec_q <= '0;
        end else if (load_i) begin
            cb_q   <= cb_d;
            v_q    <= v_d;
            cvec_q <= cvec_d;
        end
    end
endmodule

// File: rtl/dstep_unit.sv
// Module: dstep_unit (top)
// One non-restoring division iteration with a stored carry, carry vector and
// add/subtract flag. Assumes the caller feeds next_rem back as part_rem.
module dstep_unit #(
    parameter int W = dstep_pkg::DSTEP_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step_valid,
    input  logic [W-1:0]                  part_rem,
    input  logic [W-1:0]                  divisor,
    input  logic [dstep_pkg::COND_W-1:0]  cond_sel,
    output logic [W-1:0]                  next_rem,
    output logic                          cond_hit,
    output logic                          carry_msb,
    output logic                          v_flag,
    output logic [W-1:0]                  carry_vec
);
    logic         cout;
    logic         ovf;
    logic [W-1:0] cvec;
    logic         v_next;

    // Arithmetic core of the step.
    dstep_adder #(.W(W)) u_add (
        .rem_i  (part_rem),
        .div_i  (divisor),
        .cb_i   (carry_msb),
        .sub_i  (v_flag),
        .sum_o  (next_rem),
        .cout_o (cout),
        .cvec_o (cvec),
        .ovf_o  (ovf)
    );

    // Condition outcome for skipping the following operation.
    dstep_cond #(.W(W)) u_cond (
        .res_i  (next_rem),
        .cout_i (cout),
        .ovf_i  (ovf),
        .sel_i  (cond_sel),
        .hit_o  (cond_hit)
    );

    // Next mode flag: carry-out against the divisor sign.
    always_comb v_next = cout ^ divisor[W-1];

    // Flags kept across steps.
    dstep_status #(.W(W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (step_valid),
        .cb_d   (cout),
        .v_d    (v_next),
        .cvec_d (cvec),
        .cb_q   (carry_msb),
        .v_q    (v_flag),
        .cvec_q (carry_vec)
    );
endmodule

// File: rtl/dstep_unit_chk.sv
// Module: dstep_unit_chk
// Port-level properties of the division step unit, bound to the top.
module dstep_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_valid,
    input logic [W-1:0] divisor,
    input logic [3:0]   cond_sel,
    input logic [W-1:0] next_rem,
    input logic         cond_hit,
    input logic         carry_msb,
    input logic         v_flag,
    input logic [W-1:0] carry_vec
);
    // R1
    lsb_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_rem[0] == (carry_msb ^ divisor[0]));

    // R4
    vec_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> carry_vec[0] == $past(v_flag));

    // R5
    v_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> v_flag == (carry_msb ^ $past(divisor[W-1])));

    // R7
    no_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0) |-> !cond_hit);

    // R8
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> ($stable(carry_msb) && $stable(v_flag) && $stable(carry_vec)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!carry_msb && !v_flag && carry_vec == '0));
endmodule

bind dstep_unit dstep_unit_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .divisor    (divisor),
    .cond_sel   (cond_sel),
    .next_rem   (next_rem),
    .cond_hit   (cond_hit),
    .carry_msb  (carry_msb),
    .v_flag     (v_flag),
    .carry_vec  (carry_vec)
);

// File: tb/dstep_unit_tb_top.sv
module dstep_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0;
    logic [31:0] part_rem = '0;
    logic [31:0] divisor = '0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] next_rem;
    logic        cond_hit;
    logic        carry_msb;
    logic        v_flag;
    logic [31:0] carry_vec;

    always #2 clk = ~clk;  // 250 MHz

    dstep_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
        .part_rem(part_rem), .divisor(divisor), .cond_sel(cond_sel),
        .next_rem(next_rem), .cond_hit(cond_hit), .carry_msb(carry_msb),
        .v_flag(v_flag), .carry_vec(carry_vec)
    );

    typedef struct {
        logic [31:0] rem;
        logic        hit;
        logic        cb;
        logic        v;
        logic [31:0] vec;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    // Bench copy of the stored state, updated from the requirements.
    logic        m_cb = 0;
    logic        m_v  = 0;
    logic [31:0] m_vec = '0;
    logic [31:0] lfsr = 32'h1234_5679;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one step and queue what the monitor must see this cycle.
    task automatic step(input bit vld, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] cf,
                        input string tag);
        logic [31:0] sh, ad, res, vec;
        logic [32:0] w;
        logic        co, ovf, z, p;
        item_t       it;
        @(posedge clk);
        #1;
        step_valid = vld; part_rem = a; divisor = d; cond_sel = cf;
        sh  = {a[30:0], m_cb};
        ad  = m_v ? ~d : d;
        w   = {1'b0, sh} + {1'b0, ad} + {32'd0, m_v};
        res = w[31:0];
        co  = w[32];
        vec = sh ^ ad ^ res;
        ovf = (sh[31] == ad[31]) && (res[31] != sh[31]);
        z   = (res == 0);
        case (cf[3:1])
            3'd0: p = 0;
            3'd1: p = z;
            3'd2: p = res[31];
            3'd3: p = res[31] | z;
            3'd4: p = !co;
            3'd5: p = !co | z;
            3'd6: p = ovf;
            default: p = res[0];
        endcase
        it.rem = res;
        it.hit = (cf == 0) ? 1'b0 : (p ^ cf[0]);
        it.cb  = m_cb;
        it.v   = m_v;
        it.vec = m_vec;
        it.tag = tag;
        sb.push_back(it);
        if (vld) begin
            m_cb  = co;
            m_v   = co ^ d[31];
            m_vec = vec;
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 0; step_valid = 1;
        @(posedge clk);
        #1;
        rst_n = 1; step_valid = 0;
        m_cb = 0; m_v = 0; m_vec = '0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Monitor: compare the queued item on the falling edge of its cycle.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.tag, "next_rem", next_rem, it.rem);
                chk(it.tag, "cond_hit", {31'd0, cond_hit}, {31'd0, it.hit});
                chk(it.tag, "carry_msb", {31'd0, carry_msb}, {31'd0, it.cb});
                chk(it.tag, "v_flag", {31'd0, v_flag}, {31'd0, it.v});
                chk(it.tag, "carry_vec", carry_vec, it.vec);
            end
        end
    end

    initial begin
        logic [31:0] r;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        // R9 reset state visible, R1 shift with carry 0
        step(0, 32'h0000_0001, 32'h0, 4'd0, "R9");
        step(1, 32'h8000_0001, 32'h0000_0003, 4'd0, "R1");
        step(1, 32'h4000_0000, 32'h0000_0001, 4'd0, "R3");
        step(1, 32'h7fff_ffff, 32'h8000_0000, 4'd0, "R5");
        // R2 subtract mode after V is set
        step(1, 32'h0000_0010, 32'h0000_0005, 4'd0, "R2");
        step(1, 32'h0000_0000, 32'hffff_ffff, 4'd0, "R4");
        // R8 hold: flags must survive invalid steps
        step(0, 32'hdead_beef, 32'h8765_4321, 4'd3, "R8");
        step(0, 32'h1234_5678, 32'hffff_0000, 4'd0, "R8");
        step(1, 32'h0, 32'h0, 4'd0, "R8");
        // R6 / R7: sweep every selector over varied operands
        for (int k = 0; k < 6; k++) begin
            for (int c = 0; c < 16; c++) begin
                lfsr = nxt(lfsr);
                r = lfsr;
                lfsr = nxt(lfsr);
                if (c == 0)
                    step(k[0], r, lfsr, 4'(c), "R7");
                else
                    step(k[0], (k == 2) ? 32'h0 : r,
                         (k == 2) ? 32'h0 : ((k == 4) ? 32'h7fff_ffff : lfsr),
                         4'(c), "R6");
            end
        end
        // R2 / R5: prime V to 1, then a 32-step chain feeding the remainder back
        for (int t = 0; t < 4; t++) begin
            step(1, 32'h0, 32'h8000_0000, 4'd0, "R5");
            lfsr = nxt(lfsr);
            r = lfsr;
            lfsr = nxt(lfsr);
            for (int s = 0; s < 32; s++) begin
                step(1, r, {1'b0, lfsr[30:0]} | 32'd1, 4'((s % 15) + 1), "R2");
                #1 r = next_rem;
            end
        end
        // R9 mid-run reset with step_valid high
        do_reset();
        step(1, 32'hffff_ffff, 32'h0000_0001, 4'd9, "R9");
        step(1, 32'h8000_0000, 32'h8000_0000, 4'd12, "R4");
        step(0, 32'h0, 32'h0, 4'd0, "R3");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            wait (done);
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule